// File: doc/BRIEF.md
# I2C Master Acknowledge and STOP Sequencer

This block is the part of an I2C master that finishes a byte transfer on the bus. It drives two events. The first is the acknowledge bit that follows a received byte, which can be an ACK or a NACK. The second is the STOP condition that ends a transfer. Software starts each event with its own one-cycle enable pulse. A single reload-and-count-down baud counter times every phase. One baud period is N+1 system clocks, where N is the programmable reload value.

Both bus lines are open-drain. The block pulls a line low by raising that line's output enable, and releases it by lowering the enable. It samples both lines back through two-flop synchronizers. Before it times the next phase it waits for the level it expects, so a slave that stretches SCL low lengthens the acknowledge high phase. The block reports three things:
- a sticky interrupt flag when either sequence completes;
- a stop-seen status bit;
- a sticky write-collision flag for writes to the transmit data buffer that arrive while a sequence is running. Such writes are dropped.

Top module: `i2c_ack_stop_seq`

## Requirements
- R1: After reset both output enables are low, both busy outputs are low, the interrupt, stop-seen and collision flags are 0, and the data buffer holds 0.
- R2: An acknowledge-enable pulse seen while idle sets the acknowledge busy output and drives SCL low in the next cycle. The same cycle drives SDA low for ack_value 0 (ACK) or leaves it released for ack_value 1 (NACK). SCL stays driven for exactly N+1 cycles.
- R3: After the acknowledge releases SCL, the block waits until the synchronized SCL reads high and then times N+1 more cycles. Counted from the release, SCL stays undriven for H+N+4 cycles, where H is the number of cycles a slave holds SCL low after the release.
- R4: At the end of the acknowledge, the same clock edge drives SCL low again, clears the acknowledge busy output and sets the interrupt flag. The SDA level is kept.
- R5: A stop-enable pulse seen while idle sets the stop busy output and drives SDA low, with SCL held low. Once the synchronized SDA reads low, SCL is released N+1 cycles later. That is N+4 cycles after the pulse if SDA was high before, or N+2 cycles if SDA was already driven low.
- R6: During a STOP, SDA is released exactly N+1 cycles after SCL is released.
- R7: Once both synchronized lines read high after the SDA release, stop-seen is set, three cycles after the release. N+1 cycles later the stop busy output clears and the interrupt flag is set.
- R8: The stop-seen bit is cleared when any new sequence starts.
- R9: The interrupt flag stays set until irq_clr is pulsed. A completion in the same cycle as irq_clr leaves it set.
- R10: A buffer write while either busy output is high sets the collision flag and leaves the buffer unchanged. An idle write loads the buffer. The collision flag stays set until wcol_clr is pulsed, and a colliding write in the same cycle wins over the clear.
- R11: Both enables pulsed together while idle start only the acknowledge. An enable pulsed while a sequence is active is ignored and never starts a later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_reload | input | BRG_W | Baud counter reload value N |
| ack_en_set | input | 1 | Pulse: start acknowledge sequence |
| ack_value | input | 1 | Acknowledge bit: 0 ACK, 1 NACK |
| stop_en_set | input | 1 | Pulse: start STOP sequence |
| txbuf_wr | input | 1 | Write strobe for the transmit data buffer |
| txbuf_wdata | input | DATA_W | Data to write |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ack_busy | output | 1 | Acknowledge sequence running (self-clearing enable) |
| stop_busy | output | 1 | STOP sequence running (self-clearing enable) |
| irq_flag | output | 1 | Sticky sequence-complete flag |
| stop_seen | output | 1 | STOP condition observed on the bus |
| wcol_flag | output | 1 | Sticky write-collision flag |
| txbuf_q | output | DATA_W | Transmit data buffer contents |

## Verification
The bench sweeps reload values, clock-stretch lengths and both acknowledge levels. It measures every phase length in cycles and compares it with the arithmetic of R2–R7. A design that timed the high phase from the release rather than from the sampled high level would miss the stretch term H. A design that skipped the synchronizer confirmation would come out short by the sync latency. The STOP setup length depends on whether SDA was already low after an ACK, and it is checked both ways. A design that ignored the line state would show the wrong setup length. The bench also covers a clear and a colliding write in the same cycle, simultaneous enables, and enables arriving mid-sequence. An incorrect priority would drop the collision flag, start the STOP first, or queue a second sequence.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_ACK_LOW,
      SQ_ACK_REL,
      SQ_ACK_HIGH,
      SQ_STP_SDA,
      SQ_STP_SETUP,
      SQ_STP_HOLD,
      SQ_STP_CONF,
      SQ_STP_TAIL
   } seq_state_e;

endpackage

// File: rtl/i2c_as_sync.sv
module i2c_as_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("i2c_as_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_as_brg.sv
module i2c_as_brg #(
   parameter int BRG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             halt,
   input  logic [BRG_W-1:0] reload,
   output logic             tick
);

   generate
      if (BRG_W < 1) begin : g_bad_width
         $error("i2c_as_brg: BRG_W must be at least 1");
      end
   endgenerate

   localparam logic [BRG_W-1:0] CNT_ZERO = '0;
   localparam logic [BRG_W-1:0] CNT_ONE  = {{(BRG_W-1){1'b0}}, 1'b1};

   logic [BRG_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= reload;
         run_q <= 1'b1;
      end else if (halt) begin
         run_q <= 1'b0;
      end else if (run_q && cnt_q != CNT_ZERO) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign tick = run_q && (cnt_q == CNT_ZERO);

   // Period arithmetic behind R2: a load restarts the count at the reload value
   assert_brg_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (run_q && cnt_q == $past(reload)));

   // R2: once running, the count never rises without a load
   assert_brg_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !load && !halt && cnt_q != CNT_ZERO) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
   import i2c_as_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_ack,
   input  logic start_stop,
   input  logic ack_value,
   input  logic scl_s,
   input  logic sda_s,
   input  logic tick,
   output logic cnt_load,
   output logic cnt_halt,
   output logic scl_oe,
   output logic sda_oe,
   output logic ack_busy,
   output logic stop_busy,
   output logic seq_done,
   output logic stop_det,
   output logic seq_start
);

   seq_state_e state_q, state_d;
   logic       scl_oe_q, scl_oe_d;
   logic       sda_oe_q, sda_oe_d;

   always_comb begin
      state_d   = state_q;
      scl_oe_d  = scl_oe_q;
      sda_oe_d  = sda_oe_q;
      cnt_load  = 1'b0;
      cnt_halt  = 1'b0;
      seq_done  = 1'b0;
      stop_det  = 1'b0;
      seq_start = 1'b0;
      case (state_q)
         SQ_IDLE: begin
            if (start_ack) begin
               state_d   = SQ_ACK_LOW;
               scl_oe_d  = 1'b1;
               sda_oe_d  = ~ack_value;
               cnt_load  = 1'b1;
               seq_start = 1'b1;
            end else if (start_stop) begin
               state_d   = SQ_STP_SDA;
               scl_oe_d  = 1'b1;
               sda_oe_d  = 1'b1;
               seq_start = 1'b1;
            end
         end
         SQ_ACK_LOW: begin
            if (tick) begin
               state_d  = SQ_ACK_REL;
               scl_oe_d = 1'b0;
               cnt_halt = 1'b1;
            end
         end
         SQ_ACK_REL: begin
            if (scl_s) begin
               state_d  = SQ_ACK_HIGH;
               cnt_load = 1'b1;
            end
         end
         SQ_ACK_HIGH: begin
            if (tick) begin
               state_d  = SQ_IDLE;
               scl_oe_d = 1'b1;
               cnt_halt = 1'b1;
               seq_done = 1'b1;
            end
         end
         SQ_STP_SDA: begin
            if (!sda_s) begin
               state_d  = SQ_STP_SETUP;
               cnt_load = 1'b1;
            end
         end
         SQ_STP_SETUP: begin
            if (tick) begin
               state_d  = SQ_STP_HOLD;
               scl_oe_d = 1'b0;
               cnt_load = 1'b1;
            end
         end
         SQ_STP_HOLD: begin
            if (tick) begin
               state_d  = SQ_STP_CONF;
               sda_oe_d = 1'b0;
               cnt_halt = 1'b1;
            end
         end
         SQ_STP_CONF: begin
            if (scl_s && sda_s) begin
               state_d  = SQ_STP_TAIL;
               stop_det = 1'b1;
               cnt_load = 1'b1;
            end
         end
         SQ_STP_TAIL: begin
            if (tick) begin
               state_d  = SQ_IDLE;
               cnt_halt = 1'b1;
               seq_done = 1'b1;
            end
         end
         default: begin
            state_d  = SQ_IDLE;
            cnt_halt = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         scl_oe_q <= 1'b0;
         sda_oe_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         scl_oe_q <= scl_oe_d;
         sda_oe_q <= sda_oe_d;
      end
   end

   assign scl_oe    = scl_oe_q;
   assign sda_oe    = sda_oe_q;
   assign ack_busy  = (state_q == SQ_ACK_LOW) || (state_q == SQ_ACK_REL) ||
                      (state_q == SQ_ACK_HIGH);
   assign stop_busy = (state_q == SQ_STP_SDA)  || (state_q == SQ_STP_SETUP) ||
                      (state_q == SQ_STP_HOLD) || (state_q == SQ_STP_CONF)  ||
                      (state_q == SQ_STP_TAIL);

   assert_ack_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_busy) |-> (scl_oe && (sda_oe != $past(ack_value))));

   assert_ack_waits_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_busy && !scl_oe && !scl_s) |=> !scl_oe);

   assert_stop_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_busy && start_stop) |=> !stop_busy);

endmodule

// File: rtl/i2c_ack_stop_seq.sv
module i2c_ack_stop_seq #(
   parameter int BRG_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BRG_W-1:0]  brg_reload,
   input  logic              ack_en_set,
   input  logic              ack_value,
   input  logic              stop_en_set,
   input  logic              txbuf_wr,
   input  logic [DATA_W-1:0] txbuf_wdata,
   input  logic              irq_clr,
   input  logic              wcol_clr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              ack_busy,
   output logic              stop_busy,
   output logic              irq_flag,
   output logic              stop_seen,
   output logic              wcol_flag,
   output logic [DATA_W-1:0] txbuf_q
);

   localparam int N_LINES = 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("i2c_ack_stop_seq: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("i2c_ack_stop_seq: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [N_LINES-1:0] line_raw, line_s;
   logic scl_s, sda_s;
   logic tick, cnt_load, cnt_halt;
   logic seq_done, stop_det, seq_start, seq_busy;

   assign line_raw = {sda_in, scl_in};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line_sync
         i2c_as_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (line_raw[g]),
            .q     (line_s[g])
         );
      end
   endgenerate

   assign scl_s = line_s[0];
   assign sda_s = line_s[1];

   i2c_as_brg #(.BRG_W(BRG_W)) u_brg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cnt_load),
      .halt   (cnt_halt),
      .reload (brg_reload),
      .tick   (tick)
   );

   i2c_as_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ack  (ack_en_set),
      .start_stop (stop_en_set),
      .ack_value  (ack_value),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .tick       (tick),
      .cnt_load   (cnt_load),
      .cnt_halt   (cnt_halt),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe),
      .ack_busy   (ack_busy),
      .stop_busy  (stop_busy),
      .seq_done   (seq_done),
      .stop_det   (stop_det),
      .seq_start  (seq_start)
   );

   assign seq_busy = ack_busy || stop_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag  <= 1'b0;
         wcol_flag <= 1'b0;
         stop_seen <= 1'b0;
         txbuf_q   <= '0;
      end else begin
         if (seq_done)             irq_flag <= 1'b1;
         else if (irq_clr)         irq_flag <= 1'b0;

         if (txbuf_wr && seq_busy) wcol_flag <= 1'b1;
         else if (wcol_clr)        wcol_flag <= 1'b0;

         if (txbuf_wr && !seq_busy) txbuf_q <= txbuf_wdata;

         if (stop_det)             stop_seen <= 1'b1;
         else if (seq_start)       stop_seen <= 1'b0;
      end
   end

   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   assert_wcol_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (txbuf_wr && seq_busy) |=> (wcol_flag && $stable(txbuf_q)));

   assert_stop_bus_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_seen) |-> $past(scl_s && sda_s));

   assert_stop_scl_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_busy && $fell(sda_oe)) |-> !scl_oe);

endmodule

// File: tb/test_i2c_ack_stop_seq.sv
module test_i2c_ack_stop_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] brg_reload = 8'd0;
   logic       ack_en_set = 1'b0, ack_value = 1'b0, stop_en_set = 1'b0;
   logic       txbuf_wr = 1'b0;
   logic [7:0] txbuf_wdata = 8'd0;
   logic       irq_clr = 1'b0, wcol_clr = 1'b0;
   logic       scl_hold = 1'b0;
   logic       scl_in, sda_in;
   logic       scl_oe, sda_oe, ack_busy, stop_busy, irq_flag, stop_seen, wcol_flag;
   logic [7:0] txbuf_q;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   bit sda_was_low = 1'b0;

   always #4 clk = ~clk;

   assign scl_in = ~scl_oe & ~scl_hold;
   assign sda_in = ~sda_oe;

   i2c_ack_stop_seq #(.BRG_W(8), .DATA_W(8), .SYNC_STAGES(2)) i_i2c_ack_stop_seq (
      .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
      .ack_en_set(ack_en_set), .ack_value(ack_value), .stop_en_set(stop_en_set),
      .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
      .irq_clr(irq_clr), .wcol_clr(wcol_clr),
      .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_busy(ack_busy), .stop_busy(stop_busy),
      .irq_flag(irq_flag), .stop_seen(stop_seen), .wcol_flag(wcol_flag),
      .txbuf_q(txbuf_q)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic clear_irq();
      repeat (2) @(negedge clk);
      chk("R9 irq held without clear", irq_flag, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R9 irq cleared", irq_flag, 0);
   endtask

   task automatic run_ack(input int n, input int h, input logic v);
      int   lo;
      int   hi;
      logic exp_sda;
      exp_sda    = ~v;
      brg_reload = n[7:0];
      scl_hold   = 1'b1;
      ack_en_set = 1'b1;
      ack_value  = v;
      @(negedge clk);
      ack_en_set = 1'b0;
      chk("R2 ack busy", ack_busy, 1);
      chk("R2 ack scl driven", scl_oe, 1);
      chk("R2 ack sda level", sda_oe, exp_sda);
      chk("R8 stop_seen cleared at start", stop_seen, 0);
      lo = 0;
      while (scl_oe && ack_busy) begin lo++; @(negedge clk); end
      chk("R2 ack low phase", lo, n + 1);
      hi = 0;
      while (!scl_oe && ack_busy) begin
         if (hi == h) scl_hold = 1'b0;
         hi++;
         @(negedge clk);
      end
      scl_hold = 1'b0;
      chk("R3 ack high phase", hi, h + n + 4);
      chk("R4 ack busy cleared", ack_busy, 0);
      chk("R4 scl driven low again", scl_oe, 1);
      chk("R4 irq set", irq_flag, 1);
      chk("R4 sda kept", sda_oe, exp_sda);
      sda_was_low = exp_sda;
   endtask

   task automatic run_stop(input int n);
      int c1;
      int c2;
      int c3;
      int seen;
      brg_reload  = n[7:0];
      stop_en_set = 1'b1;
      @(negedge clk);
      stop_en_set = 1'b0;
      chk("R5 stop busy", stop_busy, 1);
      chk("R5 stop sda driven", sda_oe, 1);
      chk("R5 stop scl held", scl_oe, 1);
      chk("R8 stop_seen cleared at start", stop_seen, 0);
      c1 = 0;
      while (scl_oe && stop_busy) begin c1++; @(negedge clk); end
      chk("R5 stop setup length", c1, sda_was_low ? n + 2 : n + 4);
      c2 = 0;
      while (sda_oe && stop_busy) begin c2++; @(negedge clk); end
      chk("R6 sda release delay", c2, n + 1);
      c3 = 0;
      seen = 0;
      while (stop_busy) begin
         c3++;
         if (stop_seen) seen++;
         @(negedge clk);
      end
      chk("R7 tail length", c3, n + 4);
      chk("R7 stop_seen before end", seen, n + 1);
      chk("R7 stop_seen set", stop_seen, 1);
      chk("R7 irq set", irq_flag, 1);
      chk("R7 lines released", {scl_oe, sda_oe}, 0);
      sda_was_low = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int ns [5] = '{0, 1, 2, 3, 6};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe", {scl_oe, sda_oe}, 0);
      chk("R1 busy", {ack_busy, stop_busy}, 0);
      chk("R1 flags", {irq_flag, stop_seen, wcol_flag}, 0);
      chk("R1 buffer", txbuf_q, 0);

      // Sweep of reload value, stretch length and acknowledge level
      for (int i = 0; i < 5; i++) begin
         for (int h = 0; h < 4; h++) begin
            for (int v = 0; v < 2; v++) begin
               run_ack(ns[i], h, v[0]);
               clear_irq();
               run_stop(ns[i]);
               clear_irq();
            end
         end
      end

      // R10 idle write, colliding write, set-wins, clear
      txbuf_wr = 1'b1; txbuf_wdata = 8'h3C;
      @(negedge clk);
      txbuf_wr = 1'b0;
      chk("R10 idle write loads buffer", txbuf_q, 8'h3C);
      chk("R10 no collision when idle", wcol_flag, 0);
      brg_reload = 8'd4;
      ack_en_set = 1'b1; ack_value = 1'b0;
      @(negedge clk);
      ack_en_set = 1'b0;
      txbuf_wr = 1'b1; txbuf_wdata = 8'hA5; wcol_clr = 1'b1;
      @(negedge clk);
      txbuf_wr = 1'b0; wcol_clr = 1'b0;
      chk("R10 collision wins over clear", wcol_flag, 1);
      chk("R10 buffer unchanged", txbuf_q, 8'h3C);
      repeat (2) @(negedge clk);
      chk("R10 collision sticky", wcol_flag, 1);
      wcol_clr = 1'b1;
      @(negedge clk);
      wcol_clr = 1'b0;
      chk("R10 collision cleared", wcol_flag, 0);
      // R11 stop pulse during acknowledge is ignored
      stop_en_set = 1'b1;
      @(negedge clk);
      stop_en_set = 1'b0;
      while (ack_busy) @(negedge clk);
      repeat (4) begin
         chk("R11 stop during ack ignored", stop_busy, 0);
         @(negedge clk);
      end
      clear_irq();

      // R11 both enables together while idle
      ack_en_set = 1'b1; stop_en_set = 1'b1; ack_value = 1'b1;
      @(negedge clk);
      ack_en_set = 1'b0; stop_en_set = 1'b0;
      chk("R11 ack wins", ack_busy, 1);
      chk("R11 stop not started", stop_busy, 0);
      while (ack_busy) @(negedge clk);
      chk("R11 no stop after ack", stop_busy, 0);
      clear_irq();

      // R11 acknowledge pulse during STOP is ignored
      stop_en_set = 1'b1;
      @(negedge clk);
      stop_en_set = 1'b0;
      ack_en_set = 1'b1;
      @(negedge clk);
      ack_en_set = 1'b0;
      while (stop_busy) @(negedge clk);
      repeat (4) begin
         chk("R11 ack during stop ignored", ack_busy, 0);
         @(negedge clk);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule